// File: doc/BRIEF.md
# DMA Channel Request Capture Unit

This unit sits in front of a 16-channel DMA engine. It turns three kinds of trigger into per-channel service requests: rising edges on 32 hardware request lines, software trigger writes, and chain triggers raised when another channel finishes its programmed transfers. Each channel picks its hardware line through a programmable select field. At reset, channel c listens to line c.

Each channel holds at most two requests: a pending slot, which drives the request toward the downstream arbiter, and one buffered entry behind it. Each captured request records the channel's transfer-type setting (one frame or a whole block) at the moment of capture. The arbiter acknowledges completion of the pending request. The buffered entry then moves up, and a chain request may go to a target channel. A request that finds both levels occupied is discarded. A software trigger is discarded if a software request already occupies the slot it would wait behind. A hardware trigger is still accepted in that case.

Top module: `dma_req_capture`

## Requirements
- R1: After reset no channel is pending or full, every channel is disabled, every stored type reads frame (0), and channel c selects hardware line c.
- R2: A low-to-high change on the line selected by an enabled channel sets that channel's `svc_req_o` bit after three rising clock edges (two synchroniser stages and one capture). A line held high for many cycles counts as one request.
- R3: A map write (`cfg_map_we_i`) sets the line select of channel `cfg_ch_i` to `cfg_sel_i`. After that, lines other than the selected one have no effect on that channel.
- R4: With the pending slot occupied, one more request goes into the buffer and raises `full_o`. Any request that arrives while `full_o` is set is discarded.
- R5: `ack_i` with `ack_ch_i` naming a pending channel frees the pending slot at the next edge. A buffered entry moves into the pending slot in that same edge, so `svc_req_o` stays set and `full_o` clears. An acknowledge on a channel that is not pending has no effect. A request arriving in the acknowledge cycle takes the first slot that the acknowledge leaves free.
- R6: A `sw_set_i[c]` pulse on enabled channel c is captured at the next edge. It is discarded if the entry that will occupy the pending slot after that edge is a software request.
- R7: A hardware request arriving while a software request is pending is captured into the buffer.
- R8: `svc_blk_o[c]` shows the type of the pending entry as it was when that entry was captured, with 1 meaning block and 0 meaning frame. A later control write does not change it. After promotion, a buffered entry shows its own type.
- R9: An acknowledge with `ack_last_i`=1 on a pending channel that has chaining enabled raises a request on its chain target channel at the same edge. With `ack_last_i`=0 no chain request is raised.
- R10: A disabled channel ignores hardware, software and chain triggers.
- R11: Triggers that reach one channel in the same cycle merge into a single request. The merged request counts as a software request only when no hardware or chain trigger is part of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hw_req_i | input | 32 | Level-active hardware request lines |
| sw_set_i | input | 16 | Software trigger, one bit per channel, one-cycle pulse |
| cfg_ch_i | input | 4 | Channel addressed by a configuration write |
| cfg_map_we_i | input | 1 | Writes the line select of the addressed channel |
| cfg_sel_i | input | 5 | Hardware line select value |
| cfg_ctl_we_i | input | 1 | Writes the control fields of the addressed channel |
| cfg_en_i | input | 1 | Channel enable |
| cfg_blk_i | input | 1 | Transfer type: 1 block, 0 frame |
| cfg_chain_en_i | input | 1 | Enable chaining on completion |
| cfg_chain_ch_i | input | 4 | Chain target channel |
| ack_i | input | 1 | Completion acknowledge from the arbiter |
| ack_ch_i | input | 4 | Channel being acknowledged |
| ack_last_i | input | 1 | The completed transfer was the channel's last |
| svc_req_o | output | 16 | Per-channel service request (pending flag) |
| svc_blk_o | output | 16 | Transfer type of each pending entry |
| full_o | output | 16 | Per-channel buffer-occupied flag |

## Verification
A wrong internal state in a channel shows at the ports within one cycle of the next acknowledge. A lost buffer entry clears `svc_req_o` when it should stay set. A phantom entry keeps it set, and a stale type shows on `svc_blk_o`. Mapping and synchroniser faults show three edges after a line rises, as a request on the wrong channel or as no request at all. A chain decode fault shows one edge after the acknowledge, on the target's `svc_req_o` bit. The bench sweeps every channel through its default and remapped lines, and it drives each drop and merge rule into the states where it matters.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  typedef struct packed {
    logic v;
    logic blk;
    logic sw;
  } slot_t;
endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int N_REQ = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REQ-1:0] req_i,
  output logic [N_REQ-1:0] rise_o
);
  logic [N_REQ-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= req_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~prev_q;
endmodule

// File: rtl/dma_req_cfg.sv
module dma_req_cfg #(
  parameter int N_CH  = 16,
  parameter int N_REQ = 32,
  localparam int CH_W  = $clog2(N_CH),
  localparam int SEL_W = $clog2(N_REQ)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [CH_W-1:0]            ch_i,
  input  logic                       map_we_i,
  input  logic [SEL_W-1:0]           sel_i,
  input  logic                       ctl_we_i,
  input  logic                       en_i,
  input  logic                       blk_i,
  input  logic                       chain_en_i,
  input  logic [CH_W-1:0]            chain_ch_i,
  output logic [N_CH-1:0][SEL_W-1:0] sel_o,
  output logic [N_CH-1:0]            en_o,
  output logic [N_CH-1:0]            blk_o,
  output logic [N_CH-1:0]            chain_en_o,
  output logic [N_CH-1:0][CH_W-1:0]  chain_ch_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam logic [SEL_W-1:0] SEL_RST = SEL_W'(c % N_REQ);
    logic hit;
    assign hit = (ch_i == CH_W'(c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sel_o[c]      <= SEL_RST;
        en_o[c]       <= 1'b0;
        blk_o[c]      <= 1'b0;
        chain_en_o[c] <= 1'b0;
        chain_ch_o[c] <= '0;
      end else begin
        if (map_we_i && hit) sel_o[c] <= sel_i;
        if (ctl_we_i && hit) begin
          en_o[c]       <= en_i;
          blk_o[c]      <= blk_i;
          chain_en_o[c] <= chain_en_i;
          chain_ch_o[c] <= chain_ch_i;
        end
      end
    end
  end
endmodule

// File: rtl/dma_req_slot.sv
module dma_req_slot
  import dma_req_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic blk_i,
  input  logic hw_ev_i,
  input  logic sw_ev_i,
  input  logic chain_ev_i,
  input  logic ack_i,
  output logic pend_o,
  output logic blk_o,
  output logic full_o
);
  slot_t pend_q, buf_q, pend_d, buf_d;
  slot_t eff_pend, eff_buf, ent;
  logic  ack_here, sw_ok, hw_any, new_ev;

  assign ack_here = ack_i & pend_q.v;
  // occupancy as it stands once this cycle's acknowledge is applied
  assign eff_pend = ack_here ? buf_q : pend_q;
  assign eff_buf  = ack_here ? slot_t'('0) : buf_q;

  assign hw_any = hw_ev_i | chain_ev_i;
  assign sw_ok  = sw_ev_i & ~(eff_pend.v & eff_pend.sw);
  assign new_ev = en_i & (hw_any | sw_ok);
  assign ent    = '{v: 1'b1, blk: blk_i, sw: ~hw_any};

  always_comb begin
    pend_d = eff_pend;
    buf_d  = eff_buf;
    if (new_ev) begin
      if (!eff_pend.v)     pend_d = ent;
      else if (!eff_buf.v) buf_d  = ent;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      buf_q  <= '0;
    end else begin
      pend_q <= pend_d;
      buf_q  <= buf_d;
    end
  end

  assign pend_o = pend_q.v;
  assign blk_o  = pend_q.v & pend_q.blk;
  assign full_o = buf_q.v;
endmodule

// File: rtl/dma_req_capture.sv
module dma_req_capture #(
  parameter int N_CH  = 16,
  parameter int N_REQ = 32,
  localparam int CH_W  = $clog2(N_CH),
  localparam int SEL_W = $clog2(N_REQ)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REQ-1:0] hw_req_i,
  input  logic [N_CH-1:0]  sw_set_i,
  input  logic [CH_W-1:0]  cfg_ch_i,
  input  logic             cfg_map_we_i,
  input  logic [SEL_W-1:0] cfg_sel_i,
  input  logic             cfg_ctl_we_i,
  input  logic             cfg_en_i,
  input  logic             cfg_blk_i,
  input  logic             cfg_chain_en_i,
  input  logic [CH_W-1:0]  cfg_chain_ch_i,
  input  logic             ack_i,
  input  logic [CH_W-1:0]  ack_ch_i,
  input  logic             ack_last_i,
  output logic [N_CH-1:0]  svc_req_o,
  output logic [N_CH-1:0]  svc_blk_o,
  output logic [N_CH-1:0]  full_o
);
  logic [N_REQ-1:0]           rise;
  logic [N_CH-1:0][SEL_W-1:0] sel_q;
  logic [N_CH-1:0]            ch_en, ch_blk, chain_en;
  logic [N_CH-1:0][CH_W-1:0]  chain_ch;
  logic [N_CH-1:0]            hw_ev, ack_vec, chain_vec;
  logic                       chain_fire;

  dma_req_sync #(.N_REQ(N_REQ)) u_sync (
    .clk_i, .rst_ni, .req_i(hw_req_i), .rise_o(rise)
  );

  dma_req_cfg #(.N_CH(N_CH), .N_REQ(N_REQ)) u_cfg (
    .clk_i, .rst_ni,
    .ch_i(cfg_ch_i), .map_we_i(cfg_map_we_i), .sel_i(cfg_sel_i),
    .ctl_we_i(cfg_ctl_we_i), .en_i(cfg_en_i), .blk_i(cfg_blk_i),
    .chain_en_i(cfg_chain_en_i), .chain_ch_i(cfg_chain_ch_i),
    .sel_o(sel_q), .en_o(ch_en), .blk_o(ch_blk),
    .chain_en_o(chain_en), .chain_ch_o(chain_ch)
  );

  assign ack_vec    = ack_i ? (N_CH'(1) << ack_ch_i) : '0;
  assign chain_fire = ack_i & ack_last_i & svc_req_o[ack_ch_i] & chain_en[ack_ch_i];
  assign chain_vec  = chain_fire ? (N_CH'(1) << chain_ch[ack_ch_i]) : '0;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign hw_ev[c] = rise[sel_q[c]];

    dma_req_slot u_slot (
      .clk_i, .rst_ni,
      .en_i(ch_en[c]), .blk_i(ch_blk[c]),
      .hw_ev_i(hw_ev[c]), .sw_ev_i(sw_set_i[c]), .chain_ev_i(chain_vec[c]),
      .ack_i(ack_vec[c]),
      .pend_o(svc_req_o[c]), .blk_o(svc_blk_o[c]), .full_o(full_o[c])
    );
  end
endmodule

// File: rtl/dma_req_capture_chk.sv
module dma_req_capture_chk #(
  parameter int N_CH = 16,
  localparam int CH_W = $clog2(N_CH)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ack_i,
  input logic [CH_W-1:0] ack_ch_i,
  input logic [N_CH-1:0] svc_req_o,
  input logic [N_CH-1:0] full_o,
  input logic [N_CH-1:0] ch_en
);
  assert_full_has_pend_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o & ~svc_req_o) == '0);

  assert_one_capture_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o & ~$past(svc_req_o)) == '0);

  assert_disabled_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_req_o & ~$past(svc_req_o) & ~$past(ch_en)) == '0);

  assert_ack_promote_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && full_o[ack_ch_i] |=> svc_req_o[$past(ack_ch_i)]);

  assert_ack_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && svc_req_o[ack_ch_i] && !full_o[ack_ch_i] && !ch_en[ack_ch_i]
    |=> !svc_req_o[$past(ack_ch_i)]);
endmodule

bind dma_req_capture dma_req_capture_chk #(.N_CH(N_CH)) u_chk (.*);

// File: tb/dma_req_capture_test.sv
module dma_req_capture_test;
  localparam int NC = 16;
  localparam int NR = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NR-1:0] hw_req = '0;
  logic [NC-1:0] sw_set = '0;
  logic [3:0]    cfg_ch = '0;
  logic          map_we = 1'b0;
  logic [4:0]    cfg_sel = '0;
  logic          ctl_we = 1'b0;
  logic          c_en = 1'b0, c_blk = 1'b0, c_cen = 1'b0;
  logic [3:0]    c_cch = '0;
  logic          ack = 1'b0, ack_last = 1'b0;
  logic [3:0]    ack_ch = '0;
  logic [NC-1:0] svc_req, svc_blk, full;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  dma_req_capture uut (
    .clk_i(clk), .rst_ni(rst_ni), .hw_req_i(hw_req), .sw_set_i(sw_set),
    .cfg_ch_i(cfg_ch), .cfg_map_we_i(map_we), .cfg_sel_i(cfg_sel),
    .cfg_ctl_we_i(ctl_we), .cfg_en_i(c_en), .cfg_blk_i(c_blk),
    .cfg_chain_en_i(c_cen), .cfg_chain_ch_i(c_cch),
    .ack_i(ack), .ack_ch_i(ack_ch), .ack_last_i(ack_last),
    .svc_req_o(svc_req), .svc_blk_o(svc_blk), .full_o(full)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic ctl(input int ch, input logic en, input logic blk,
                     input logic cen, input int cch);
    cfg_ch = 4'(ch); c_en = en; c_blk = blk; c_cen = cen; c_cch = 4'(cch);
    ctl_we = 1'b1; step(); ctl_we = 1'b0;
  endtask

  task automatic map(input int ch, input int sel);
    cfg_ch = 4'(ch); cfg_sel = 5'(sel);
    map_we = 1'b1; step(); map_we = 1'b0;
  endtask

  // result visible on return (three edges after the rise)
  task automatic pulse(input int line);
    hw_req[line] = 1'b1; step(); hw_req[line] = 1'b0; step(); step();
  endtask

  task automatic sw(input int ch);
    sw_set[ch] = 1'b1; step(); sw_set[ch] = 1'b0;
  endtask

  task automatic do_ack(input int ch, input logic last);
    ack = 1'b1; ack_ch = 4'(ch); ack_last = last; step();
    ack = 1'b0; ack_last = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    step(); step();
    rst_ni = 1'b1;
    step();
    chk("R1 reset pend", 32'(svc_req), 32'h0);
    chk("R1 reset full", 32'(full), 32'h0);
    chk("R1 reset type", 32'(svc_blk), 32'h0);

    // default mapping sweep: channel c answers line c only
    for (int c = 0; c < NC; c++) begin
      ctl(c, 1'b1, 1'b0, 1'b0, 0);
      pulse(c);
      chk("R1 R2 default line", 32'(svc_req), 32'(1) << c);
      do_ack(c, 1'b0);
      chk("R5 ack clears", 32'(svc_req), 32'h0);
      ctl(c, 1'b0, 1'b0, 1'b0, 0);
    end

    // remap sweep
    for (int c = 0; c < NC; c++) begin
      int s;
      s = (c * 5 + 7) % NR;
      map(c, s);
      ctl(c, 1'b1, 1'b0, 1'b0, 0);
      pulse(c);
      chk("R3 old line ignored", 32'(svc_req), 32'h0);
      pulse(s);
      chk("R3 new line", 32'(svc_req), 32'(1) << c);
      do_ack(c, 1'b0);
      ctl(c, 1'b0, 1'b0, 1'b0, 0);
      map(c, c);
    end

    // two-level buffer and drop
    ctl(2, 1'b1, 1'b0, 1'b0, 0);
    pulse(2);
    chk("R4 first pend", 32'(svc_req), 32'h4);
    chk("R4 first not full", 32'(full), 32'h0);
    pulse(2);
    chk("R4 second full", 32'(full), 32'h4);
    pulse(2);
    chk("R4 third keeps full", 32'(full), 32'h4);
    do_ack(2, 1'b0);
    chk("R5 promote pend", 32'(svc_req), 32'h4);
    chk("R5 promote full clr", 32'(full), 32'h0);
    do_ack(2, 1'b0);
    chk("R4 third dropped", 32'(svc_req), 32'h0);
    do_ack(2, 1'b0);
    chk("R5 ack idle ignored", 32'(svc_req | full), 32'h0);

    // held-high line counts once
    ctl(3, 1'b1, 1'b0, 1'b0, 0);
    hw_req[3] = 1'b1;
    repeat (10) step();
    chk("R2 held pend", 32'(svc_req), 32'h8);
    chk("R2 held once", 32'(full), 32'h0);
    hw_req[3] = 1'b0;
    step(); step();
    do_ack(3, 1'b0);
    chk("R2 held cleared", 32'(svc_req), 32'h0);

    // software rules
    ctl(4, 1'b1, 1'b0, 1'b0, 0);
    sw(4);
    chk("R6 sw captured", 32'(svc_req), 32'h10);
    sw(4);
    chk("R6 repeated sw dropped", 32'(full), 32'h0);
    pulse(4);
    chk("R7 hw behind sw", 32'(full), 32'h10);
    do_ack(4, 1'b0); do_ack(4, 1'b0);
    chk("R7 drained", 32'(svc_req | full), 32'h0);
    pulse(4);
    sw(4);
    chk("R6 sw behind hw", 32'(full), 32'h10);
    do_ack(4, 1'b0); do_ack(4, 1'b0);
    chk("R6 drained", 32'(svc_req | full), 32'h0);

    // transfer type
    ctl(5, 1'b1, 1'b1, 1'b0, 0);
    sw(5);
    chk("R8 block type", 32'(svc_blk), 32'h20);
    ctl(5, 1'b1, 1'b0, 1'b0, 0);
    chk("R8 type held", 32'(svc_blk), 32'h20);
    pulse(5);
    do_ack(5, 1'b0);
    chk("R8 promoted pend", 32'(svc_req), 32'h20);
    chk("R8 promoted frame", 32'(svc_blk), 32'h0);
    do_ack(5, 1'b0);

    // chaining 6 -> 9
    ctl(9, 1'b1, 1'b0, 1'b0, 0);
    ctl(6, 1'b1, 1'b0, 1'b1, 9);
    sw(6);
    do_ack(6, 1'b0);
    chk("R9 not last no chain", 32'(svc_req), 32'h0);
    sw(6);
    do_ack(6, 1'b1);
    chk("R9 chain raised", 32'(svc_req), 32'h200);
    do_ack(9, 1'b0);
    ctl(9, 1'b0, 1'b0, 1'b0, 0);
    sw(6);
    do_ack(6, 1'b1);
    chk("R10 chain to disabled", 32'(svc_req), 32'h0);

    // disabled channel
    sw(7);
    chk("R10 sw disabled", 32'(svc_req), 32'h0);
    pulse(7);
    chk("R10 hw disabled", 32'(svc_req), 32'h0);

    // merge: hw edge and sw in the same capture cycle
    ctl(8, 1'b1, 1'b0, 1'b0, 0);
    hw_req[8] = 1'b1; step(); step();
    sw_set[8] = 1'b1; step(); sw_set[8] = 1'b0; hw_req[8] = 1'b0;
    chk("R11 merged pend", 32'(svc_req), 32'h100);
    chk("R11 merged single", 32'(full), 32'h0);
    sw(8);
    chk("R11 merged is hw", 32'(full), 32'h100);
    do_ack(8, 1'b0); do_ack(8, 1'b0);

    // request in the acknowledge cycle
    ctl(11, 1'b1, 1'b0, 1'b0, 0);
    sw(11);
    sw_set[11] = 1'b1; ack = 1'b1; ack_ch = 4'd11; step();
    sw_set[11] = 1'b0; ack = 1'b0;
    chk("R5 R6 refill on ack", 32'(svc_req), 32'h800);
    chk("R5 refill not full", 32'(full), 32'h0);
    do_ack(11, 1'b0);
    chk("R5 final clear", 32'(svc_req | full), 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule